// File: doc/BRIEF.md
# SDRAM power-down and refresh sequencer

This block drives the command pins and clock enable of a single SDRAM device for a small read-only controller. Its main job is power saving. When a two-bit low-power selector holds the power-down code and the bus has been idle for a set number of cycles, it pulls the clock enable low and holds it there. In this mode the memory does no refreshing of its own. The sequencer therefore keeps a free-running refresh timer. When that timer expires, the sequencer wakes the device, issues an auto-refresh, waits out the recovery time and then drops back into power-down.

A host read arrives through a request/acknowledge port. A request also wakes the device. The sequencer opens the row, waits the activate-to-read delay, and issues a burst of column reads to consecutive columns, one per cycle. Data is returned from the data pins two cycles after each read command. The acknowledge pulses together with the last data word. All banks are then closed with a precharge-all. A refresh that falls due while the sequencer is idle is served before a waiting host request.

Top module: `sdramPdSeq`

## Requirements
- R1: While reset is held, sdCke is 1, the command pins {sdCsN,sdRasN,sdCasN,sdWeN} show NOP (4'b0111), and reqAck and rdValid are 0.
- R2: sdCke is driven low only when lpMode equals 2'b10 and no request or refresh is waiting for IDLE_CYC consecutive idle cycles. Any other lpMode value keeps sdCke high.
- R3: Command encodings on {sdCsN,sdRasN,sdCasN,sdWeN} are: NOP 0111, ACTIVE 0011, READ 0101, PRECHARGE 0010, AUTO REFRESH 0001. Every cycle in which sdCke is low carries NOP.
- R4: A host request, a due refresh, or lpMode leaving 2'b10 ends power-down. The first cycle with sdCke high again carries NOP.
- R5: Auto-refresh commands are issued on a free-running schedule of REF_CYC cycles. Two of them, or reset and the first one, are never more than REF_CYC+TRCD+BURST+CAS_LAT+TRFC+6 cycles apart, including during power-down.
- R6: The first READ after an ACTIVE comes exactly TRCD (3) cycles after it, and the ACTIVE carries reqRow on sdAddr.
- R7: A request produces BURST back-to-back READ commands. Their sdAddr carries the columns reqCol, reqCol+1, and so on (modulo 2^COL_W, zero-extended, bit 10 low).
- R8: rdValid is high exactly CAS_LAT (2) cycles after each READ command, and in that cycle rdData equals sdDq.
- R9: reqAck is a one-cycle pulse that coincides with the last rdValid of the burst. A PRECHARGE with sdAddr bit 10 high follows before the next ACTIVE or AUTO REFRESH.
- R10: After a refresh or a request has been served, and while lpMode still equals 2'b10, the block returns to power-down once the idle period has elapsed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| lpMode | input | 2 | Low-power selector, 2'b10 selects power-down |
| reqValid | input | 1 | Host read request, held until reqAck |
| reqRow | input | ROW_W | Row of the requested burst |
| reqCol | input | COL_W | First column of the requested burst |
| reqAck | output | 1 | Pulses with the last data word |
| rdValid | output | 1 | rdData holds a read word this cycle |
| rdData | output | DATA_W | Read data word |
| sdCke | output | 1 | SDRAM clock enable |
| sdCsN | output | 1 | SDRAM chip select, active low |
| sdRasN | output | 1 | SDRAM row strobe, active low |
| sdCasN | output | 1 | SDRAM column strobe, active low |
| sdWeN | output | 1 | SDRAM write enable, active low |
| sdAddr | output | ROW_W | SDRAM address pins |
| sdDq | input | DATA_W | SDRAM data pins |

## Verification
The bench builds the block with REF_CYC of 60 and IDLE_CYC of 4, keeping TRCD 3, CAS_LAT 2, TRFC 3 and BURST 4. With a refresh every 60 cycles and power-down after 4 idle cycles, one long idle stretch wakes the device for refresh several times and re-enters power-down each time. Requests therefore land both in power-down and in the awake idle state. A burst that starts at column 0x1FE exercises column wrap-around.

// File: rtl/sdpd_pkg.sv
package sdpd_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_READ,
    CMD_PRE,
    CMD_REF
  } sdCmd_e;

  // {csN, rasN, casN, weN}
  localparam logic [3:0] PIN_NOP  = 4'b0111;
  localparam logic [3:0] PIN_ACT  = 4'b0011;
  localparam logic [3:0] PIN_READ = 4'b0101;
  localparam logic [3:0] PIN_PRE  = 4'b0010;
  localparam logic [3:0] PIN_REF  = 4'b0001;

  localparam logic [1:0] MODE_PDOWN = 2'b10;

  typedef struct packed {
    sdCmd_e cmd;
    logic   ckeLow;
    logic   loadAddr;
    logic   lastRead;
  } ctrlStrb_t;

endpackage

// File: rtl/sdpd_ctrl.sv
module sdpd_ctrl
  import sdpd_pkg::*;
#(
  parameter int REF_CYC  = 780,
  parameter int IDLE_CYC = 16,
  parameter int TRCD     = 3,
  parameter int TRFC     = 3,
  parameter int BURST    = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic [1:0] lpMode,
  input  logic      reqValid,
  input  logic      burstDone,
  output ctrlStrb_t strb
);

  localparam int CNT_MAX = ((IDLE_CYC > BURST) ? IDLE_CYC : BURST) + TRCD + TRFC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int REF_W   = $clog2(REF_CYC + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_PDOWN, S_EXIT, S_REF, S_RWAIT,
    S_ACT, S_TWAIT, S_READ, S_DRAIN, S_PRE
  } state_e;

  state_e           state;
  logic [CNT_W-1:0] waitCnt;
  logic [REF_W-1:0] refCnt;
  logic             refPending;
  logic             pdSel;

  assign pdSel = (lpMode == MODE_PDOWN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      refCnt     <= REF_W'(REF_CYC - 1);
      refPending <= 1'b0;
    end else if (refCnt == '0) begin
      refCnt     <= REF_W'(REF_CYC - 1);
      refPending <= 1'b1;
    end else begin
      refCnt <= refCnt - 1'b1;
      if (state == S_REF) refPending <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      waitCnt <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (refPending) state <= S_REF;
          else if (reqValid) state <= S_ACT;
          else if (pdSel && waitCnt == CNT_W'(IDLE_CYC - 1)) state <= S_PDOWN;
          else if (waitCnt != CNT_W'(IDLE_CYC - 1)) waitCnt <= waitCnt + 1'b1;
        end
        S_PDOWN: if (refPending || reqValid || !pdSel) state <= S_EXIT;
        S_EXIT: begin
          state   <= S_IDLE;
          waitCnt <= '0;
        end
        S_REF, S_PRE: begin
          state   <= S_RWAIT;
          waitCnt <= '0;
        end
        S_RWAIT: begin
          if (waitCnt == CNT_W'(TRFC - 1)) begin
            state   <= S_IDLE;
            waitCnt <= '0;
          end else waitCnt <= waitCnt + 1'b1;
        end
        S_ACT: begin
          state   <= S_TWAIT;
          waitCnt <= '0;
        end
        S_TWAIT: begin
          if (waitCnt == CNT_W'(TRCD - 2)) begin
            state   <= S_READ;
            waitCnt <= '0;
          end else waitCnt <= waitCnt + 1'b1;
        end
        S_READ: begin
          if (waitCnt == CNT_W'(BURST - 1)) state <= S_DRAIN;
          else waitCnt <= waitCnt + 1'b1;
        end
        S_DRAIN: if (burstDone) state <= S_PRE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strb = '{cmd: CMD_NOP, ckeLow: 1'b0, loadAddr: 1'b0, lastRead: 1'b0};
    unique case (state)
      S_PDOWN: strb.ckeLow = 1'b1;
      S_REF:   strb.cmd = CMD_REF;
      S_PRE:   strb.cmd = CMD_PRE;
      S_ACT: begin
        strb.cmd      = CMD_ACT;
        strb.loadAddr = 1'b1;
      end
      S_READ: begin
        strb.cmd      = CMD_READ;
        strb.lastRead = (waitCnt == CNT_W'(BURST - 1));
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sdpd_datapath.sv
module sdpd_datapath
  import sdpd_pkg::*;
#(
  parameter int ROW_W   = 13,
  parameter int COL_W   = 9,
  parameter int DATA_W  = 16,
  parameter int CAS_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrb_t         strb,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic [DATA_W-1:0] sdDq,
  output logic              sdCke,
  output logic [3:0]        cmdPins,
  output logic [ROW_W-1:0]  sdAddr,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              burstDone
);

  localparam int A10 = 10;

  logic [COL_W-1:0]   colReg;
  logic               readPin, lastPin;
  logic [CAS_LAT-1:0] readPipe, lastPipe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdCke   <= 1'b1;
      cmdPins <= PIN_NOP;
      sdAddr  <= '0;
      colReg  <= '0;
      readPin <= 1'b0;
      lastPin <= 1'b0;
    end else begin
      sdCke   <= !strb.ckeLow;
      readPin <= (strb.cmd == CMD_READ);
      lastPin <= strb.lastRead;
      if (strb.loadAddr) colReg <= reqCol;
      unique case (strb.cmd)
        CMD_ACT: begin
          cmdPins <= PIN_ACT;
          sdAddr  <= reqRow;
        end
        CMD_READ: begin
          cmdPins <= PIN_READ;
          sdAddr  <= ROW_W'(colReg);
          colReg  <= colReg + 1'b1;
        end
        CMD_PRE: begin
          cmdPins <= PIN_PRE;
          sdAddr  <= ROW_W'(1) << A10;
        end
        CMD_REF: cmdPins <= PIN_REF;
        default: cmdPins <= PIN_NOP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      readPipe <= '0;
      lastPipe <= '0;
    end else begin
      readPipe[0] <= readPin;
      lastPipe[0] <= lastPin;
      for (int i = 1; i < CAS_LAT; i++) begin
        readPipe[i] <= readPipe[i-1];
        lastPipe[i] <= lastPipe[i-1];
      end
    end
  end

  assign rdValid   = readPipe[CAS_LAT-1];
  assign rdData    = sdDq;
  assign burstDone = lastPipe[CAS_LAT-1];

endmodule

// File: rtl/sdramPdSeq.sv
module sdramPdSeq
  import sdpd_pkg::*;
#(
  parameter int ROW_W    = 13,
  parameter int COL_W    = 9,
  parameter int DATA_W   = 16,
  parameter int BURST    = 4,
  parameter int TRCD     = 3,
  parameter int CAS_LAT  = 2,
  parameter int TRFC     = 3,
  parameter int REF_CYC  = 780,
  parameter int IDLE_CYC = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        lpMode,
  input  logic              reqValid,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  output logic              reqAck,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic              sdCke,
  output logic              sdCsN,
  output logic              sdRasN,
  output logic              sdCasN,
  output logic              sdWeN,
  output logic [ROW_W-1:0]  sdAddr,
  input  logic [DATA_W-1:0] sdDq
);

  ctrlStrb_t  strb;
  logic [3:0] cmdPins;
  logic       burstDone;

  sdpd_ctrl #(
    .REF_CYC(REF_CYC), .IDLE_CYC(IDLE_CYC), .TRCD(TRCD), .TRFC(TRFC), .BURST(BURST)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .lpMode(lpMode), .reqValid(reqValid),
    .burstDone(burstDone), .strb(strb)
  );

  sdpd_datapath #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .CAS_LAT(CAS_LAT)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqRow(reqRow), .reqCol(reqCol),
    .sdDq(sdDq), .sdCke(sdCke), .cmdPins(cmdPins), .sdAddr(sdAddr),
    .rdValid(rdValid), .rdData(rdData), .burstDone(burstDone)
  );

  assign {sdCsN, sdRasN, sdCasN, sdWeN} = cmdPins;
  assign reqAck = burstDone;

endmodule

// File: rtl/sdpd_checker.sv
module sdpd_checker #(
  parameter int ROW_W   = 13,
  parameter int BURST   = 4,
  parameter int TRCD    = 3,
  parameter int CAS_LAT = 2,
  parameter int TRFC    = 3,
  parameter int REF_CYC = 780
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       lpMode,
  input logic             reqAck,
  input logic             rdValid,
  input logic             sdCke,
  input logic             sdCsN,
  input logic             sdRasN,
  input logic             sdCasN,
  input logic             sdWeN,
  input logic [ROW_W-1:0] sdAddr
);

  localparam int REF_LIMIT = REF_CYC + TRCD + BURST + CAS_LAT + TRFC + 6;

  logic [3:0] pins;
  logic isNop, isAct, isRead, isPre, isRef;
  int   sinceRef;

  assign pins   = {sdCsN, sdRasN, sdCasN, sdWeN};
  assign isNop  = (pins == 4'b0111);
  assign isAct  = (pins == 4'b0011);
  assign isRead = (pins == 4'b0101);
  assign isPre  = (pins == 4'b0010);
  assign isRef  = (pins == 4'b0001);

  always_ff @(posedge clk) begin
    if (!rstN) sinceRef <= 0;
    else if (isRef) sinceRef <= 0;
    else sinceRef <= sinceRef + 1;
  end

  // R2
  cke_entry_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdCke) |-> ($past(lpMode, 2) == 2'b10));

  // R3
  cke_low_nop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sdCke |-> isNop);

  // R4
  exit_nop_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdCke) |-> isNop);

  // R5
  ref_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    sinceRef <= REF_LIMIT);

  // R6
  act_to_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isRead && !$past(isRead)) |-> $past(isAct, TRCD));

  // R8
  read_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid == $past(isRead, CAS_LAT));

  // R9
  ack_with_data_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |-> (rdValid && !$past(reqAck)));

  // R9
  pre_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    isPre |-> sdAddr[10]);

endmodule

bind sdramPdSeq sdpd_checker #(
  .ROW_W(ROW_W), .BURST(BURST), .TRCD(TRCD), .CAS_LAT(CAS_LAT),
  .TRFC(TRFC), .REF_CYC(REF_CYC)
) i_sdpd_checker (
  .clk(clk), .rstN(rstN), .lpMode(lpMode), .reqAck(reqAck), .rdValid(rdValid),
  .sdCke(sdCke), .sdCsN(sdCsN), .sdRasN(sdRasN), .sdCasN(sdCasN),
  .sdWeN(sdWeN), .sdAddr(sdAddr)
);

// File: tb/test_sdramPdSeq.sv
module test_sdramPdSeq;

  localparam int CLK_PERIOD = 10;
  localparam int ROW_W = 13, COL_W = 9, DATA_W = 16, BURST = 4;
  localparam int TRCD = 3, CAS_LAT = 2, TRFC = 3, REF_CYC = 60, IDLE_CYC = 4;
  localparam int REF_LIMIT = REF_CYC + TRCD + BURST + CAS_LAT + TRFC + 6;

  // {mode[1:0], row[12:0], col[8:0], gap[7:0]}
  localparam int NVEC = 6;
  localparam logic [31:0] VEC [NVEC] = '{
    {2'd0, 13'h0011, 9'h000, 8'd2},
    {2'd2, 13'h1ABC, 9'h010, 8'd20},
    {2'd1, 13'h0FFF, 9'h1F8, 8'd20},
    {2'd2, 13'h1FFF, 9'h1FE, 8'd3},
    {2'd3, 13'h0000, 9'h005, 8'd18},
    {2'd2, 13'h0155, 9'h0A0, 8'd30}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [1:0]        lpMode = 2'd0;
  logic              reqValid = 1'b0;
  logic [ROW_W-1:0]  reqRow = '0;
  logic [COL_W-1:0]  reqCol = '0;
  logic              reqAck, rdValid, sdCke, sdCsN, sdRasN, sdCasN, sdWeN;
  logic [DATA_W-1:0] rdData;
  logic [ROW_W-1:0]  sdAddr;
  logic [DATA_W-1:0] sdDq = '0;

  int checks = 0;
  int errors = 0;

  sdramPdSeq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .BURST(BURST), .TRCD(TRCD),
    .CAS_LAT(CAS_LAT), .TRFC(TRFC), .REF_CYC(REF_CYC), .IDLE_CYC(IDLE_CYC)
  ) i_sdramPdSeq (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DATA_W-1:0] memWord(logic [ROW_W-1:0] r, logic [COL_W-1:0] c);
    return {r[6:0] ^ 7'h2B, c};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor / device model state
  logic [ROW_W-1:0]  curRow = '0;
  logic [COL_W-1:0]  curCol = '0;
  logic [DATA_W-1:0] gotWords [BURST];
  int  gotN = 0;
  int  readIdx = 0;
  int  actAge = 100;
  int  sinceRef = 0;
  int  refCount = 0;
  int  ckeRises = 0;
  bit  sawLow = 0;
  bit  prevCke = 1;
  bit  prevAck = 0;
  bit  vp1 = 0, vp2 = 0;
  bit  preSeen = 1;
  logic [ROW_W-1:0]  actRow = '0;
  logic [DATA_W-1:0] d1 = '0, d2 = '0;

  always @(posedge clk) sdDq <= d2;

  always @(negedge clk) begin
    if (rstN) begin
      logic [3:0] cmd;
      bit expV;
      cmd = {sdCsN, sdRasN, sdCasN, sdWeN};
      if (!sdCke) begin
        sawLow = 1;
        check(cmd == 4'b0111, "R3 nop while cke low", cmd, 4'b0111);
      end
      if (sdCke && !prevCke) begin
        ckeRises++;
        check(cmd == 4'b0111, "R4 nop on cke rise", cmd, 4'b0111);
      end
      prevCke = sdCke;
      sinceRef++;
      if (cmd == 4'b0001) begin
        check(sinceRef <= REF_LIMIT, "R5 refresh interval", sinceRef, REF_LIMIT);
        check(preSeen, "R9 precharge before refresh", 0, 1);
        sinceRef = 0;
        refCount++;
      end
      if (cmd == 4'b0010) begin
        preSeen = 1;
        check(sdAddr[10] == 1'b1, "R9 precharge A10", sdAddr, 1 << 10);
      end
      if (actAge < 100) actAge++;
      if (cmd == 4'b0011) begin
        check(preSeen, "R9 precharge before activate", 0, 1);
        check(sdAddr == curRow, "R6 activate row", sdAddr, curRow);
        preSeen = 0;
        actAge = 0;
        readIdx = 0;
        actRow = sdAddr;
      end
      d2 = d1;
      d1 = 'x;
      if (cmd == 4'b0101) begin
        logic [COL_W-1:0] ec;
        ec = curCol + COL_W'(readIdx);
        if (readIdx == 0) check(actAge == TRCD, "R6 activate to read", actAge, TRCD);
        check(sdAddr == ROW_W'(ec), "R7 read column", sdAddr, ec);
        d1 = memWord(actRow, sdAddr[COL_W-1:0]);
        readIdx++;
      end
      expV = vp2;
      vp2 = vp1;
      vp1 = (cmd == 4'b0101);
      if (rdValid || expV) check(rdValid == expV, "R8 rdValid timing", rdValid, expV);
      if (rdValid && gotN < BURST) begin
        gotWords[gotN] = rdData;
        gotN++;
      end
      if (reqAck) begin
        check(rdValid && !prevAck && gotN == BURST, "R9 ack with last word", gotN, BURST);
      end
      prevAck = reqAck;
    end
  end

  task automatic idleFor(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doReq(input logic [ROW_W-1:0] r, input logic [COL_W-1:0] c);
    int t;
    curRow = r;
    curCol = c;
    gotN = 0;
    reqRow = r;
    reqCol = c;
    reqValid = 1'b1;
    t = 0;
    do begin
      @(negedge clk);
      t++;
    end while (!reqAck && t < 300);
    reqValid = 1'b0;
    check(t < 300, "R9 request acknowledged", t, 300);
    @(negedge clk);
    check(!reqAck, "R9 ack one-cycle pulse", reqAck, 0);
    for (int i = 0; i < BURST; i++) begin
      logic [COL_W-1:0] cc;
      cc = c + COL_W'(i);
      check(gotWords[i] == memWord(r, cc), "R8 read data word", gotWords[i], memWord(r, cc));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(sdCke == 1'b1, "R1 reset cke", sdCke, 1);
    check({sdCsN, sdRasN, sdCasN, sdWeN} == 4'b0111, "R1 reset command",
          {sdCsN, sdRasN, sdCasN, sdWeN}, 4'b0111);
    check(!reqAck && !rdValid, "R1 reset ack/valid", {reqAck, rdValid}, 0);
    rstN = 1'b1;

    // table of requests under different modes and idle gaps
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] m;
      int gap;
      m = VEC[v][31:30];
      gap = int'(VEC[v][7:0]);
      lpMode = m;
      @(negedge clk);
      @(negedge clk);
      sawLow = 0;
      idleFor(gap);
      if (m != 2'b10) check(!sawLow, "R2 no power-down for other mode", sawLow, 0);
      else if (gap >= 16) check(sawLow, "R2 power-down entered", sawLow, 1);
      doReq(VEC[v][29:17], VEC[v][16:8]);
    end

    // R4: leaving the mode ends power-down
    lpMode = 2'b10;
    idleFor(16);
    check(!sdCke, "R2 cke low after idle", sdCke, 0);
    lpMode = 2'b00;
    idleFor(4);
    check(sdCke, "R4 mode change wakes device", sdCke, 1);
    sawLow = 0;
    idleFor(40);
    check(!sawLow, "R2 stays awake with mode 0", sawLow, 1'b0);

    // R5 / R10: refresh wake-ups during long power-down, with re-entry
    begin
      int r0, k0;
      lpMode = 2'b10;
      idleFor(12);
      r0 = refCount;
      k0 = ckeRises;
      idleFor(3 * REF_CYC + 10);
      check(refCount - r0 >= 3, "R5 refreshes during power-down", refCount - r0, 3);
      check(ckeRises - k0 >= 3, "R10 wake-ups for refresh", ckeRises - k0, 3);
      idleFor(2);
      sawLow = 0;
      idleFor(16);
      check(sawLow, "R10 re-entry after refresh", sawLow, 1);
    end

    // request arriving while in power-down
    wait (!sdCke);
    @(negedge clk);
    doReq(13'h0A5A, 9'h1FF);
    sawLow = 0;
    idleFor(20);
    check(sawLow, "R10 re-entry after request", sawLow, 1);
    check(refCount > 0, "R5 refresh seen", refCount, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule